// File: doc/BRIEF.md
# Freezable Channel Activity Counters

This block keeps four 32-bit counters that measure how a radio MAC spends its time. One counter counts every clock. The other three count the clocks on which the receive medium is sensed busy, the clocks spent receiving a frame, and the clocks spent sending a frame. Each counter has its own per-cycle status input. All four share one clock and one freeze point, so software can later work out the idle listen time. That time is the total count less the receive-frame and transmit-frame counts.

Software uses a small word-addressed register interface. A control word holds a freeze bit and four sticky overflow flags. To take a snapshot, software sets freeze, reads the four counters, writes zero to each one, and then writes zero to the control word. Counting then resumes with no skew between the counters. A counter stops at all ones instead of wrapping, and its overflow flag records that it hit the limit.

Top module: `act_cnt_top`

## Requirements
- R1: Synchronous active-low reset clears all four counters, the freeze bit and all overflow flags.
- R2: Word address 1 is the total counter. It adds one on every clock edge while the block is not frozen.
- R3: Word addresses 2, 3 and 4 count busy, receive-frame and transmit-frame cycles. Each adds one only on edges where its status input is high and the block is not frozen.
- R4: Control word bit 0 is the freeze bit, at word address 0. While it is set, none of the four counters changes except by a register write. The freeze value written at one edge applies from the next edge on.
- R5: Reads are combinational from `reg_addr`. Address 0 returns freeze in bit 0 and the overflow flags in bits 8 to 11 (total, busy, receive-frame, transmit-frame), with all other bits zero. Addresses 1 to 4 return the counters, and addresses 5 to 7 read as zero.
- R6: A write to a counter address loads `reg_wdata` into that counter, so writing zero clears it. A write wins over an increment on the same edge.
- R7: A counter at all ones stays at all ones when further increments arrive. It never wraps.
- R8: A counter's overflow flag is set when an increment arrives while that counter is at all ones. The flag stays set until that counter is written. Writes to the control word do not change the flags.
- R9: Writes to addresses 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all counters |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Receive medium busy this cycle |
| rx_frame_i | input | 1 | Frame reception in progress this cycle |
| tx_frame_i | input | 1 | Frame transmission in progress this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
The bench checks that freeze takes effect one edge after the control write and that every counter stays constant for as long as freeze holds. A design that froze one edge early or late would be off by one, and one that missed a counter would show skew between them. The bench loads values just below all ones and keeps counting, to catch a counter that wraps to zero or an overflow flag that is missing, not sticky, or cleared by a control write. It also writes to a counter while that counter's status input is high, to catch an increment that wins over the load. It writes to unused addresses to catch decode aliasing.

// File: rtl/act_cnt_pkg.sv
// Package: shared constants for the activity counter block.
// Assumes word addressing: control at 0, counters from 1 upward.
package act_cnt_pkg;

    localparam int unsigned NUM_CNT  = 4;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned FRZ_BIT  = 0;
    localparam int unsigned OVF_LSB  = 8;

    // Counter slots; the index plus one is the word address.
    typedef enum logic [1:0] {
        SLOT_TOTAL = 2'd0,
        SLOT_BUSY  = 2'd1,
        SLOT_RXF   = 2'd2,
        SLOT_TXF   = 2'd3
    } cnt_slot_e;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_BASE = 3'd1;

endpackage

// File: rtl/act_cnt_counter.sv
// Module: one saturating activity counter with a sticky overflow flag.
// Assumes the freeze input is already registered. A write loads the
// counter and clears its flag, and it wins over an increment.
module act_cnt_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic at_max;
    logic step_req;

    assign at_max   = (value == CNT_MAX);
    assign step_req = inc && !freeze;

    // Counter register: load, else saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end else if (step_req && !at_max) begin
            value <= value + W'(1);
        end
    end

    // Overflow flag: set on an increment at the limit, cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wr_en) begin
            ovf <= 1'b0;
        end else if (step_req && at_max) begin
            ovf <= 1'b1;
        end
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en) |=> $stable(value)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !freeze && !wr_en && value != CNT_MAX) |=> (value == $past(value) + W'(1))); // R3
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data))); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (value == CNT_MAX && !wr_en) |=> (value == CNT_MAX)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_en) |=> ovf); // R8

endmodule

// File: rtl/act_cnt_regdec.sv
// Module: write decode for the register interface.
// Assumes one write per cycle. Addresses past the last counter decode
// to nothing.
module act_cnt_regdec
    import act_cnt_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              ctrl_wr,
    output logic [N-1:0]      cnt_wr
);
    // Control write strobe.
    assign ctrl_wr = wr_en && (addr == ADR_CTRL);

    for (genvar gi = 0; gi < N; gi++) begin : g_dec
        // Counter write strobe for slot gi.
        assign cnt_wr[gi] = wr_en && (addr == ADR_CNT_BASE + ADDR_W'(gi));
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr, cnt_wr})); // R9

endmodule

// File: rtl/act_cnt_ctrl.sv
// Module: the freeze bit of the control word.
// Assumes the overflow bits of the control word are read-only, so only
// the freeze bit is stored here.
module act_cnt_ctrl
    import act_cnt_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic [W-1:0] wr_data,
    output logic         freeze
);
    // Freeze register: loads bit FRZ_BIT on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze <= 1'b0;
        end else if (ctrl_wr) begin
            freeze <= wr_data[FRZ_BIT];
        end
    end

    AST_FREEZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(freeze)); // R4

endmodule

// File: rtl/act_cnt_top.sv
// Module: four freezable activity counters behind a word register interface.
// Assumes one clock for everything and status inputs that are already
// synchronous to it. Reads are combinational.
module act_cnt_top
    import act_cnt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              rx_frame_i,
    input  logic              tx_frame_i,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned N = NUM_CNT;

    logic              ctrl_wr;
    logic [N-1:0]      cnt_wr;
    logic              freeze;
    logic [N-1:0]      inc_vec;
    logic [N-1:0]      ovf_vec;
    logic [DATA_W-1:0] cnt_val [N];
    logic [DATA_W-1:0] ctrl_word;

    // Increment requests per slot; the total counter always asks.
    assign inc_vec[SLOT_TOTAL] = 1'b1;
    assign inc_vec[SLOT_BUSY]  = busy_i;
    assign inc_vec[SLOT_RXF]   = rx_frame_i;
    assign inc_vec[SLOT_TXF]   = tx_frame_i;

    act_cnt_regdec #(.N(N)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .ctrl_wr (ctrl_wr),
        .cnt_wr  (cnt_wr)
    );

    act_cnt_ctrl #(.W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wr_data (reg_wdata),
        .freeze  (freeze)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_cnt
        act_cnt_counter #(.W(DATA_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .freeze  (freeze),
            .inc     (inc_vec[gi]),
            .wr_en   (cnt_wr[gi]),
            .wr_data (reg_wdata),
            .value   (cnt_val[gi]),
            .ovf     (ovf_vec[gi])
        );
    end

    // Control word image: freeze bit plus the overflow flags.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[FRZ_BIT] = freeze;
        ctrl_word[OVF_LSB +: N] = ovf_vec;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_CTRL) begin
            reg_rdata = ctrl_word;
        end
        for (int i = 0; i < N; i++) begin
            if (reg_addr == ADR_CNT_BASE + ADDR_W'(i)) begin
                reg_rdata = cnt_val[i];
            end
        end
    end

    AST_COMMON_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && cnt_wr == '0) |=> ($stable(cnt_val[SLOT_TOTAL]) && $stable(cnt_val[SLOT_TXF]))); // R4

endmodule

// File: tb/test_act_cnt_top.sv
module test_act_cnt_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy_i = 1'b0;
    logic         rx_frame_i = 1'b0;
    logic         tx_frame_i = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    act_cnt_top i_act_cnt_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .rx_frame_i (rx_frame_i),
        .tx_frame_i (tx_frame_i),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    // Reference model, built from the requirements.
    logic [W-1:0] m_cnt [4];
    logic [3:0]   m_ovf;
    logic         m_frz;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_cnt[i] <= '0;
            m_ovf <= '0;
            m_frz <= 1'b0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic inc;
                inc = (i == 0) ? 1'b1 : (i == 1) ? busy_i : (i == 2) ? rx_frame_i : tx_frame_i;
                if (reg_wr_en && reg_addr == 3'(i + 1)) begin
                    m_cnt[i] <= reg_wdata;
                    m_ovf[i] <= 1'b0;
                end else if (!m_frz && inc) begin
                    if (m_cnt[i] == '1) m_ovf[i] <= 1'b1;
                    else m_cnt[i] <= m_cnt[i] + 1;
                end
            end
            if (reg_wr_en && reg_addr == 3'd0) m_frz <= reg_wdata[0];
        end
    end

    function automatic logic [W-1:0] model_read(input logic [2:0] a);
        logic [W-1:0] v;
        v = '0;
        if (a == 3'd0) begin
            v[0] = m_frz;
            v[11:8] = m_ovf;
        end else if (a <= 3'd4) begin
            v = m_cnt[a - 1];
        end
        return v;
    endfunction

    typedef struct {
        logic [2:0]   addr;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];

    // Driver: present a read address and push the expected word.
    task automatic expect_read(input logic [2:0] a, input string tag);
        item_t it;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_addr = a;
        it.addr = a;
        it.exp = model_read(a);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Driver: one register write, held for one edge.
    task automatic reg_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Driver: a varied status pattern for n cycles.
    task automatic run_status(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            busy_i = ((k + seed) % 2) == 0;
            rx_frame_i = ((k + seed) % 3) == 0;
            tx_frame_i = ((k + seed) % 5) == 1;
        end
    endtask

    task automatic read_all(input string tag);
        for (int a = 1; a <= 4; a++) expect_read(3'(a), tag);
    endtask

    // Monitor: compare the sampled read data with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (reg_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] snap [4];
        repeat (3) @(negedge clk);
        // R1: reset state, read while reset is held.
        expect_read(3'd0, "R1");
        read_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: free run with a varied pattern, then freeze and read.
        run_status(37, 0);
        reg_write(3'd0, 32'h1);
        read_all("R2 R3 frozen snapshot");
        expect_read(3'd0, "R5 freeze bit readback");
        for (int a = 0; a < 4; a++) snap[a] = m_cnt[a];

        // R4: status keeps toggling while frozen.
        run_status(20, 1);
        read_all("R4 counters hold while frozen");
        for (int a = 0; a < 4; a++) begin
            checks++;
            if (m_cnt[a] !== snap[a]) begin
                failures++;
                $display("FAIL R4 model moved slot=%0d actual=%h expected=%h", a, m_cnt[a], snap[a]);
            end
        end

        // R6: clear sequence then resume.
        for (int a = 1; a <= 4; a++) reg_write(3'(a), '0);
        read_all("R6 cleared");
        reg_write(3'd0, 32'h0);
        run_status(13, 2);
        read_all("R2 R3 after resume");

        // R6: write wins over increment while running with status high.
        @(negedge clk);
        busy_i = 1'b1; rx_frame_i = 1'b1; tx_frame_i = 1'b1;
        reg_write(3'd2, 32'h0000_1234);
        expect_read(3'd2, "R6 load beats increment");

        // R7 R8: saturation at all ones while running.
        reg_write(3'd0, 32'h1);
        for (int a = 1; a <= 4; a++) reg_write(3'(a), 32'hFFFF_FFFD);
        reg_write(3'd0, 32'h0);
        repeat (6) @(negedge clk);
        read_all("R7 saturated");
        expect_read(3'd0, "R8 overflow flags set");

        // R8: a control write leaves the flags alone.
        reg_write(3'd0, 32'h0000_0F00);
        expect_read(3'd0, "R8 control write keeps flags");

        // R8: writing one counter clears only its own flag.
        reg_write(3'd4, 32'h0);
        busy_i = 1'b0; rx_frame_i = 1'b0; tx_frame_i = 1'b0;
        expect_read(3'd0, "R8 write clears own flag");
        expect_read(3'd4, "R6 cleared transmit counter");

        // R9 R5: unused addresses, frozen so nothing else moves.
        reg_write(3'd0, 32'h1);
        for (int a = 1; a <= 4; a++) snap[a-1] = m_cnt[a-1];
        reg_write(3'd5, 32'hDEAD_BEEF);
        reg_write(3'd6, 32'h0000_0000);
        reg_write(3'd7, 32'h0000_0F00);
        expect_read(3'd0, "R9 control unchanged");
        read_all("R9 counters unchanged");
        expect_read(3'd6, "R5 unused address reads zero");
        expect_read(3'd7, "R5 unused address reads zero");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule